// File: doc/BRIEF.md
# Synchronous Buck Gate Sequencer

This block sequences the two gate enables of one synchronous buck phase. It runs on a fast system clock. A one-cycle strobe marks the rising edge of the slower switching clock. On each strobe the sequencer either starts a switching period or skips it. A period has four parts in order: a dead interval, the high-side conduction time, a second dead interval, and the low-side conduction time.

The high-side pulse ends at the first of these events: the peak-current comparator trips, the on-time reaches its ceiling, or the current-limit flag asserts. The current-limit flag also drops the high-side enable at once, in the same cycle. The on-time ceiling is the smaller of a fixed maximum-duty count and a soft-start ceiling input. The low side conducts until the next switching edge. It turns off earlier if the inductor current reaches zero, which gives diode emulation.

If the output is above regulation at a switching edge, the whole period is skipped with both gates off. A fault-clamp input forces the low side on and the high side off. Dropping the enable input returns the phase to idle with both gates off.

Top module: `gate_sequencer`

## Requirements
- R1: When a switching-edge strobe is sampled high while enabled, unclamped, with the above-regulation flag low and the sequencer idle or in low-side conduction, both enables stay low for D system cycles and then the high-side enable rises. D is the dead-time input, with a value of 0 treated as 1.
- R2: The high-side enable stays high for at most L system cycles and then falls. L is the smaller of MAX_ON (default 19, which is 95% of a 20-cycle switching period) and the soft-start ceiling, with a ceiling of 0 treated as 1.
- R3: After the high-side enable falls, both enables stay low for D system cycles and then the low-side enable rises.
- R4: The low-side enable stays high until a switching-edge strobe or the zero-current flag is sampled, and falls at that edge. After a zero-current exit, both enables stay low until the next switching-edge strobe.
- R5: A switching-edge strobe sampled while the above-regulation flag is high skips the period: both enables are low from that edge until a later strobe arrives with the flag low. Switching then resumes as in R1.
- R6: A peak-current trip sampled during high-side conduction ends the pulse at that clock edge, before the ceiling is reached.
- R7: While the current-limit flag is high, the high-side enable is low in the same cycle, with no clock edge in between. The pulse then proceeds to the second dead interval as in R3.
- R8: Lowering the soft-start ceiling shortens the high-side pulse to the ceiling value, as R2 states.
- R9: A dead-time input of 1 or 0 gives a one-cycle dead interval on both transitions.
- R10: While the fault clamp is sampled high, the low-side enable is high and the high-side enable is low from the next edge on, and switching strobes have no effect. After the clamp is released, both enables go low and stay low until a new strobe.
- R11: With enable sampled low, both gate enables are low from the next edge and the sequencer returns to idle. After reset both enables are low. Raising enable again does not restart switching before the next strobe.
- R12: The high-side and low-side enables are never both high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Phase enable |
| faultClamp | input | 1 | Forces low side on, high side off |
| cycleEdge | input | 1 | One-cycle strobe at each switching-clock rising edge |
| peakTrip | input | 1 | Peak-current comparator has tripped |
| curLimit | input | 1 | Current limit exceeded (acts combinationally on the high side) |
| zeroCross | input | 1 | Inductor current has reached zero |
| aboveReg | input | 1 | Output is above regulation |
| deadTime | input | DT_W | Dead interval in system cycles (0 acts as 1) |
| softCeil | input | ON_W | Soft-start ceiling on high-side cycles |
| hsOn | output | 1 | High-side gate enable |
| lsOn | output | 1 | Low-side gate enable |

## Verification
A strobe sampled at edge t leaves both gates low after edges t through t+D-1. The high side shows after edge t+D and stays up for L edges. The low side rises D edges after the high side falls. Peak trip, zero-current, clamp, enable and skip decisions all take effect on the edge that samples them. Current limit alone takes effect combinationally, in the same cycle. The bench changes inputs and reads outputs at the falling clock edge. It counts edges from the sampling edge to each expected transition and checks at that exact cycle. The current-limit check is made one time unit after the flag is raised, with no clock edge in between.

// File: rtl/gseq_pkg.sv
package gseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEAD_HI,
    ST_HIGH,
    ST_DEAD_LO,
    ST_LOW,
    ST_CLAMP
  } seqState_t;

  // strobes from control to the timing datapath
  typedef struct packed {
    logic loadDead;
    logic decDead;
    logic loadOn;
    logic incOn;
  } dpCtl_t;

endpackage

// File: rtl/gseq_dp.sv
module gseq_dp
  import gseq_pkg::*;
#(
  parameter int DT_W   = 4,
  parameter int ON_W   = 5,
  parameter int MAX_ON = 19
) (
  input  logic            clk,
  input  logic            rstN,
  input  dpCtl_t          ctl,
  input  logic [DT_W-1:0] deadTime,
  input  logic [ON_W-1:0] softCeil,
  output logic            deadDone,
  output logic            onDone
);

  localparam logic [ON_W-1:0] MAX_ON_V = ON_W'(MAX_ON);
  localparam logic [ON_W-1:0] ONE_ON   = ON_W'(1);
  localparam logic [DT_W-1:0] ONE_DT   = DT_W'(1);

  logic [DT_W-1:0] deadCnt;
  logic [DT_W-1:0] effDead;
  logic [ON_W-1:0] onCnt;
  logic [ON_W-1:0] ceilSel;
  logic [ON_W-1:0] onLimit;

  // a zero dead time still yields one cycle of separation
  assign effDead = (deadTime == '0) ? ONE_DT : deadTime;

  // on-time ceiling: smaller of max duty and soft-start, at least one cycle
  assign ceilSel = (softCeil < MAX_ON_V) ? softCeil : MAX_ON_V;
  assign onLimit = (ceilSel == '0) ? ONE_ON : ceilSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      deadCnt <= '0;
    end else if (ctl.loadDead) begin
      deadCnt <= effDead;
    end else if (ctl.decDead) begin
      deadCnt <= deadCnt - ONE_DT;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onCnt <= '0;
    end else if (ctl.loadOn) begin
      onCnt <= ONE_ON;
    end else if (ctl.incOn) begin
      onCnt <= onCnt + ONE_ON;
    end
  end

  assign deadDone = (deadCnt <= ONE_DT);
  assign onDone   = (onCnt >= onLimit);

endmodule

// File: rtl/gseq_ctrl.sv
module gseq_ctrl
  import gseq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      faultClamp,
  input  logic      cycleEdge,
  input  logic      peakTrip,
  input  logic      curLimit,
  input  logic      zeroCross,
  input  logic      aboveReg,
  input  logic      deadDone,
  input  logic      onDone,
  output seqState_t curState,
  output dpCtl_t    ctl,
  output logic      hsOn,
  output logic      lsOn
);

  seqState_t nxtState;

  always_comb begin
    nxtState = curState;
    ctl      = '0;
    if (!enable) begin
      nxtState = ST_IDLE;
    end else if (faultClamp) begin
      nxtState = ST_CLAMP;
    end else begin
      unique case (curState)
        ST_IDLE: begin
          if (cycleEdge && !aboveReg) begin
            nxtState     = ST_DEAD_HI;
            ctl.loadDead = 1'b1;
          end
        end
        ST_DEAD_HI: begin
          if (deadDone) begin
            nxtState   = ST_HIGH;
            ctl.loadOn = 1'b1;
          end else begin
            ctl.decDead = 1'b1;
          end
        end
        ST_HIGH: begin
          if (curLimit || peakTrip || onDone) begin
            nxtState     = ST_DEAD_LO;
            ctl.loadDead = 1'b1;
          end else begin
            ctl.incOn = 1'b1;
          end
        end
        ST_DEAD_LO: begin
          if (deadDone) begin
            nxtState = ST_LOW;
          end else begin
            ctl.decDead = 1'b1;
          end
        end
        ST_LOW: begin
          if (cycleEdge) begin
            if (aboveReg) begin
              nxtState = ST_IDLE;
            end else begin
              nxtState     = ST_DEAD_HI;
              ctl.loadDead = 1'b1;
            end
          end else if (zeroCross) begin
            nxtState = ST_IDLE;
          end
        end
        ST_CLAMP: nxtState = ST_IDLE;
        default:  nxtState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curState <= ST_IDLE;
    end else begin
      curState <= nxtState;
    end
  end

  // current limit cuts the high side without waiting for an edge
  assign hsOn = (curState == ST_HIGH) && !curLimit;
  assign lsOn = (curState == ST_LOW) || (curState == ST_CLAMP);

endmodule

// File: rtl/gate_sequencer.sv
module gate_sequencer
  import gseq_pkg::*;
#(
  parameter int DT_W   = 4,
  parameter int ON_W   = 5,
  parameter int MAX_ON = 19
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enable,
  input  logic            faultClamp,
  input  logic            cycleEdge,
  input  logic            peakTrip,
  input  logic            curLimit,
  input  logic            zeroCross,
  input  logic            aboveReg,
  input  logic [DT_W-1:0] deadTime,
  input  logic [ON_W-1:0] softCeil,
  output logic            hsOn,
  output logic            lsOn
);

  seqState_t curState;
  dpCtl_t    ctl;
  logic      deadDone;
  logic      onDone;

  gseq_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .faultClamp (faultClamp),
    .cycleEdge  (cycleEdge),
    .peakTrip   (peakTrip),
    .curLimit   (curLimit),
    .zeroCross  (zeroCross),
    .aboveReg   (aboveReg),
    .deadDone   (deadDone),
    .onDone     (onDone),
    .curState   (curState),
    .ctl        (ctl),
    .hsOn       (hsOn),
    .lsOn       (lsOn)
  );

  gseq_dp #(
    .DT_W   (DT_W),
    .ON_W   (ON_W),
    .MAX_ON (MAX_ON)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .deadTime (deadTime),
    .softCeil (softCeil),
    .deadDone (deadDone),
    .onDone   (onDone)
  );

endmodule

// File: rtl/gate_sequencer_chk.sv
module gate_sequencer_chk
  import gseq_pkg::*;
#(
  parameter int ON_W   = 5,
  parameter int MAX_ON = 19
) (
  input logic      clk,
  input logic      rstN,
  input logic      enable,
  input logic      faultClamp,
  input logic      cycleEdge,
  input logic      aboveReg,
  input logic      curLimit,
  input logic      hsOn,
  input logic      lsOn,
  input seqState_t curState
);

  // consecutive high-side cycles seen before the current one
  logic [ON_W:0] hsRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsRun <= '0;
    end else if (hsOn) begin
      hsRun <= hsRun + 1'b1;
    end else begin
      hsRun <= '0;
    end
  end

  a_r12_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(hsOn && lsOn));

  a_r2_max_duty: assert property (@(posedge clk) disable iff (!rstN)
    hsOn |-> (hsRun < (ON_W+1)'(MAX_ON)));

  a_r1_dead_before_high: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hsOn) |-> $past(!lsOn));

  a_r3_dead_before_low: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(lsOn) && !$past(faultClamp)) |-> $past(!hsOn));

  a_r5_skip_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !faultClamp && cycleEdge && aboveReg &&
     (curState == ST_IDLE || curState == ST_LOW)) |=> (!hsOn && !lsOn));

  a_r7_limit_cuts_high: assert property (@(posedge clk) disable iff (!rstN)
    curLimit |-> !hsOn);

  a_r10_clamp_low: assert property (@(posedge clk) disable iff (!rstN)
    (enable && faultClamp) |=> (lsOn && !hsOn));

  a_r11_disable_off: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!hsOn && !lsOn));

endmodule

bind gate_sequencer gate_sequencer_chk #(
  .ON_W   (ON_W),
  .MAX_ON (MAX_ON)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .enable     (enable),
  .faultClamp (faultClamp),
  .cycleEdge  (cycleEdge),
  .aboveReg   (aboveReg),
  .curLimit   (curLimit),
  .hsOn       (hsOn),
  .lsOn       (lsOn),
  .curState   (curState)
);

// File: tb/gate_sequencer_tb_top.sv
module gate_sequencer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DT_W   = 4;
  localparam int ON_W   = 5;
  localparam int MAX_ON = 19;

  logic clk = 1'b0;
  logic rstN, enable, faultClamp, cycleEdge, peakTrip, curLimit, zeroCross, aboveReg;
  logic [DT_W-1:0] deadTime;
  logic [ON_W-1:0] softCeil;
  logic hsOn, lsOn;

  int checks = 0;
  int errors = 0;
  int overlapSeen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gate_sequencer #(.DT_W(DT_W), .ON_W(ON_W), .MAX_ON(MAX_ON)) dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .faultClamp(faultClamp),
    .cycleEdge(cycleEdge), .peakTrip(peakTrip), .curLimit(curLimit),
    .zeroCross(zeroCross), .aboveReg(aboveReg), .deadTime(deadTime),
    .softCeil(softCeil), .hsOn(hsOn), .lsOn(lsOn)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // one rising edge, then settle at the falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    if (hsOn && lsOn) overlapSeen++;
  endtask

  task automatic stepN(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic pulseEdge();
    cycleEdge = 1'b1;
    step();
    cycleEdge = 1'b0;
  endtask

  task automatic goIdle();
    zeroCross = 1'b1;
    step();
    zeroCross = 1'b0;
  endtask

  // called right after pulseEdge; d = effective dead time, l = on-time
  task automatic runPulse(input string tag, input int d, input int l);
    chk({tag, " R1 low at strobe"}, lsOn, 1'b0);
    stepN(d - 1);
    chk({tag, " R1 high still off"}, hsOn, 1'b0);
    step();
    chk({tag, " R1 high on after dead"}, hsOn, 1'b1);
    stepN(l - 1);
    chk({tag, " R2 high held to ceiling"}, hsOn, 1'b1);
    step();
    chk({tag, " R2 high off after ceiling"}, hsOn, 1'b0);
    stepN(d - 1);
    chk({tag, " R3 low still off"}, lsOn, 1'b0);
    step();
    chk({tag, " R3 low on after dead"}, lsOn, 1'b1);
  endtask

  task automatic testReset();
    rstN = 1'b0; enable = 1'b1; faultClamp = 1'b0; cycleEdge = 1'b0;
    peakTrip = 1'b0; curLimit = 1'b0; zeroCross = 1'b0; aboveReg = 1'b0;
    deadTime = 4'd3; softCeil = 5'd31;
    stepN(2);
    chk("R11 reset high", hsOn, 1'b0);
    chk("R11 reset low", lsOn, 1'b0);
    rstN = 1'b1;
    stepN(2);
    chk("R11 idle after reset", hsOn | lsOn, 1'b0);
  endtask

  task automatic testNormal();
    pulseEdge();
    runPulse("normal", 3, MAX_ON);
    stepN(5);
    chk("R4 low holds until edge", lsOn, 1'b1);
    pulseEdge();
    chk("R4 low off at edge", lsOn, 1'b0);
    runPulse("from-low", 3, MAX_ON);
    goIdle();
    chk("R4 zero current ends low", lsOn, 1'b0);
    stepN(10);
    chk("R4 stays idle after zero", hsOn | lsOn, 1'b0);
  endtask

  task automatic testSkip();
    int seen = 0;
    aboveReg = 1'b1;
    pulseEdge();
    for (int k = 0; k < 20; k++) begin
      if (hsOn || lsOn) seen++;
      step();
    end
    pulseEdge();
    stepN(10);
    chk("R5 skipped periods stay off", (seen == 0) && !hsOn && !lsOn, 1'b1);
    aboveReg = 1'b0;
    pulseEdge();
    runPulse("R5 resume", 3, MAX_ON);
    aboveReg = 1'b1;
    pulseEdge();
    chk("R5 skip from low", hsOn | lsOn, 1'b0);
    stepN(6);
    chk("R5 skip from low holds", hsOn | lsOn, 1'b0);
    aboveReg = 1'b0;
  endtask

  task automatic testPeak();
    pulseEdge();
    stepN(3);
    chk("R6 high on", hsOn, 1'b1);
    stepN(2);
    peakTrip = 1'b1;
    step();
    peakTrip = 1'b0;
    chk("R6 peak ends high", hsOn, 1'b0);
    stepN(2);
    chk("R6 dead after peak", lsOn, 1'b0);
    step();
    chk("R6 low after peak dead", lsOn, 1'b1);
    goIdle();
  endtask

  task automatic testCurLimit();
    pulseEdge();
    stepN(3);
    chk("R7 high on", hsOn, 1'b1);
    curLimit = 1'b1;
    #1;
    chk("R7 limit cuts high same cycle", hsOn, 1'b0);
    step();
    curLimit = 1'b0;
    chk("R7 high stays off", hsOn, 1'b0);
    stepN(2);
    chk("R7 dead after limit", lsOn, 1'b0);
    step();
    chk("R7 low after limit dead", lsOn, 1'b1);
    goIdle();
  endtask

  task automatic testSoft();
    softCeil = 5'd5;
    pulseEdge();
    runPulse("R8 ceil5", 3, 5);
    goIdle();
    softCeil = 5'd0;
    pulseEdge();
    runPulse("R8 ceil0", 3, 1);
    goIdle();
    softCeil = 5'd31;
  endtask

  task automatic testDead();
    deadTime = 4'd1;
    pulseEdge();
    runPulse("R9 dead1", 1, MAX_ON);
    goIdle();
    deadTime = 4'd0;
    pulseEdge();
    runPulse("R9 dead0", 1, MAX_ON);
    goIdle();
    deadTime = 4'd3;
  endtask

  task automatic testFault();
    pulseEdge();
    stepN(4);
    chk("R10 high before clamp", hsOn, 1'b1);
    faultClamp = 1'b1;
    step();
    chk("R10 clamp high off", hsOn, 1'b0);
    chk("R10 clamp low on", lsOn, 1'b1);
    pulseEdge();
    chk("R10 strobe ignored in clamp", lsOn & !hsOn, 1'b1);
    faultClamp = 1'b0;
    step();
    chk("R10 release to idle", hsOn | lsOn, 1'b0);
    stepN(5);
    chk("R10 idle after release", hsOn | lsOn, 1'b0);
  endtask

  task automatic testDisable();
    pulseEdge();
    runPulse("R11 pre", 3, MAX_ON);
    enable = 1'b0;
    step();
    chk("R11 disable drops low", hsOn | lsOn, 1'b0);
    stepN(3);
    enable = 1'b1;
    stepN(5);
    chk("R11 no restart without strobe", hsOn | lsOn, 1'b0);
    pulseEdge();
    stepN(3);
    chk("R11 high on again", hsOn, 1'b1);
    enable = 1'b0;
    step();
    chk("R11 disable drops high", hsOn | lsOn, 1'b0);
    enable = 1'b1;
    stepN(2);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    @(negedge clk);
    testReset();
    testNormal();
    testSkip();
    testPeak();
    testCurLimit();
    testSoft();
    testDead();
    testFault();
    testDisable();
    chk("R12 no overlap seen", overlapSeen == 0, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule